// File: doc/BRIEF.md
# SCL Synchronizing Clock Generator

This block produces the clock waveform of a bus master on an open-drain, wired-AND SCL line. It only ever pulls the line low or lets it go. Each cycle it reads back the real line level through a synchronized input. It counts its own low time and then releases the line. It counts high time only once the line is actually seen high. If any other device pulls the line low during the high phase, it starts a new low phase at once. As a result, the shared clock follows the longest low time and the shortest high time of all the devices that drive it. A slave that stretches a bit looks to the block like a competing master with a long low time. No special handling is needed for it.

The byte engine can hold the clock low for as long as it likes by raising a hold request while the low phase runs. Two single-cycle strobes come from the synchronized line level. One marks a rising SCL edge, where data is sampled. The other marks a falling edge, where data may change. Both period counts are given in system-clock cycles and are read at the start of each phase.

Top module: `scl_sync_clkgen`

## Requirements
- R1: While `en` is low, or while `rst_n` is low, `scl_drive_low`, `scl_rise` and `scl_fall` are all 0. Dropping `en` releases the line in the same cycle.
- R2: After `en` goes high, the block drives SCL low (`scl_drive_low`=1) for `low_cnt` consecutive cycles and then releases it, provided no hold is requested.
- R3: After release, the block waits until `scl_in` reads 1 before it starts timing the high phase. Assume `scl_in` is the line level delayed by one register. Then a line freed at once gives a released interval of `high_cnt`+2 cycles. A line held low by another device for P cycles from the start of the low phase (P > `low_cnt`) gives `high_cnt`+2+P−`low_cnt` cycles.
- R4: The high phase lasts `high_cnt` cycles, counted from the cycle after `scl_in` is first seen high. It is followed directly by a new low phase of `low_cnt` cycles.
- R5: If `scl_in` reads 0 during the high phase, the block drives low in the next cycle. Suppose the line is pulled low k cycles after the cycle with the rise strobe. Then the released interval is k+3 cycles, for k < `high_cnt`−1.
- R6: While `hold_low` is 1 the low phase does not end. Suppose hold is raised in the first low cycle and dropped in cycle M of the low phase. Then the low pulse lasts max(`low_cnt`, M+1) cycles.
- R7: `scl_rise` is 1 in exactly those enabled cycles where `scl_in` is 1 and was 0 in the previous cycle. `scl_fall` is 1 in exactly those where `scl_in` is 0 and was 1. The two are never 1 together.
- R8: A period count of 0 behaves as 1. Low and high phases are never shorter than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enables clock generation; low releases the line |
| low_cnt | input | CNT_W | Low phase length in system cycles |
| high_cnt | input | CNT_W | High phase length in system cycles |
| hold_low | input | 1 | Byte engine request to keep SCL low |
| scl_in | input | 1 | Synchronized SCL line level |
| scl_drive_low | output | 1 | Pull-down enable for the SCL pad |
| scl_rise | output | 1 | One-cycle strobe on a synchronized rising edge |
| scl_fall | output | 1 | One-cycle strobe on a synchronized falling edge |

## Verification
A phase register stuck in, or skipping, the wait-for-high state changes the released interval at the port. It appears either as a gap that ignores a stretched line, or as a high phase that never ends. The scoreboard sees this at the first low-to-high or high-to-low change of `scl_drive_low` after the fault, within one SCL period. A faulty phase counter moves the pulse lengths off `low_cnt` or `high_cnt`+2 on the first pulse. A faulty edge register appears at once as a strobe in the wrong cycle, because every strobe cycle is compared with a model of the line level.

// File: rtl/sclg_pkg.sv
// Shared types for the SCL synchronizing clock generator.
package sclg_pkg;

    // Phase of the generated clock.
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,   // disabled, line released
        PH_LOW  = 2'd1,   // pulling SCL low, low count running
        PH_WAIT = 2'd2,   // released, line not yet seen high
        PH_HIGH = 2'd3    // released, high count running
    } sclg_phase_e;

endpackage

// File: rtl/sclg_edge_det.sv
// Edge strobes of the synchronized SCL level.
// Assumes lvl is already synchronized to clk; an idle line reads high.
module sclg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;

    // Remember the level of the previous cycle (idle high after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl;
    end

    assign rise = rst_n & en &  lvl & ~lvl_q;
    assign fall = rst_n & en & ~lvl &  lvl_q;

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
    p_rise_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (lvl && !$past(lvl)));
    p_fall_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (!lvl && $past(lvl)));
endmodule

// File: rtl/sclg_phase_timer.sv
// Up-counter that times one clock phase.
// Assumes restart is raised in the first cycle of each phase. A period of 0
// is treated as 1. The counter stops once the period has been reached.
module sclg_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] period,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = (period == '0) ? '0 : period - ONE;
    assign done  = (cnt >= limit);

    // Count the cycles spent in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (!done)        cnt <= cnt + ONE;
    end

    p_done_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> (done || !$stable(period) || restart));
endmodule

// File: rtl/sclg_phase_ctrl.sv
// Phase sequencer: low, wait for the line to rise, high, then low again.
// Assumes scl_in is synchronized. The low phase ends only when the low
// count is done and no hold is requested. The high phase ends early when
// the line is seen low.
module sclg_phase_ctrl
    import sclg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        scl_in,
    input  logic        hold_low,
    input  logic        low_done,
    input  logic        high_done,
    output sclg_phase_e phase,
    output logic        phase_restart
);
    sclg_phase_e nxt;

    // Next phase from the counters and the observed line level.
    always_comb begin
        nxt = phase;
        if (!en) begin
            nxt = PH_OFF;
        end else begin
            unique case (phase)
                PH_OFF:  nxt = PH_LOW;
                PH_LOW:  if (low_done && !hold_low) nxt = PH_WAIT;
                PH_WAIT: if (scl_in) nxt = PH_HIGH;
                PH_HIGH: if (!scl_in || high_done) nxt = PH_LOW;
                default: nxt = PH_OFF;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_OFF;
        else        phase <= nxt;
    end

    assign phase_restart = (nxt != phase) || (phase == PH_OFF);

    p_low_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT && $past(phase) == PH_LOW) |-> $past(low_done && !hold_low));
    p_wait_for_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH && $past(phase) == PH_WAIT) |-> $past(scl_in));
    p_high_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase == PH_HIGH && high_done) |=> (phase == PH_LOW || phase == PH_OFF));
    p_line_low_ends_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase == PH_HIGH && !scl_in) |=> (phase == PH_LOW || phase == PH_OFF));
endmodule

// File: rtl/scl_sync_clkgen.sv
// SCL clock generator for a master on a wired-AND line.
// It times its low phase, releases the line, and waits for the line to read
// high. It then times the high phase, and restarts the low phase early if
// the line drops. Assumes scl_in is the synchronized line level and that the
// period counts change only while en is low.
module scl_sync_clkgen
    import sclg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic             hold_low,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             scl_rise,
    output logic             scl_fall
);
    sclg_phase_e      phase;
    logic             phase_restart;
    logic             cnt_done;
    logic [CNT_W-1:0] cur_period;

    // Select the period of the phase now running.
    assign cur_period = (phase == PH_LOW) ? low_cnt : high_cnt;

    sclg_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (phase_restart),
        .period  (cur_period),
        .done    (cnt_done)
    );

    sclg_phase_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .scl_in        (scl_in),
        .hold_low      (hold_low),
        .low_done      (cnt_done),
        .high_done     (cnt_done),
        .phase         (phase),
        .phase_restart (phase_restart)
    );

    sclg_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .lvl   (scl_in),
        .rise  (scl_rise),
        .fall  (scl_fall)
    );

    assign scl_drive_low = en && (phase == PH_LOW);

    p_off_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!scl_drive_low && !scl_rise && !scl_fall));
    p_hold_keeps_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && scl_drive_low && hold_low) |=> (scl_drive_low || !en));
endmodule

// File: tb/scl_sync_clkgen_tb.sv
module scl_sync_clkgen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [CW-1:0] low_cnt = '0;
    logic [CW-1:0] high_cnt = '0;
    logic hold_low = 1'b0;
    logic other_pull = 1'b0;
    logic scl_in_s = 1'b1;
    logic prev_m = 1'b1;
    logic scl_drive_low, scl_rise, scl_fall;
    logic line;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    // expected runs: kind 0 = driven low, 1 = released
    int    q_kind[$];
    int    q_len[$];
    string q_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line = !(scl_drive_low || other_pull);

    // one-register synchronizer and previous-level model
    always @(posedge clk) begin
        scl_in_s <= line;
        prev_m   <= rst_n ? scl_in_s : 1'b1;
    end

    scl_sync_clkgen #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .low_cnt(low_cnt), .high_cnt(high_cnt),
        .hold_low(hold_low), .scl_in(scl_in_s), .scl_drive_low(scl_drive_low),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int kind, int len, string req);
        q_kind.push_back(kind);
        q_len.push_back(len);
        q_req.push_back(req);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_drive();
        do @(negedge clk); while (!scl_drive_low);
        #1;
    endtask

    task automatic start(int l, int h);
        step();
        en = 1'b0; hold_low = 1'b0; other_pull = 1'b0;
        low_cnt = CW'(l); high_cnt = CW'(h);
        step(); step();
        en = 1'b1;
    endtask

    task automatic finish_case(string req);
        int n = 0;
        while (q_len.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(q_len.size() == 0, req, "pending runs", q_len.size(), 0);
        #1;
        en = 1'b0;
        q_kind.delete(); q_len.delete(); q_req.delete();
        step();
    endtask

    // monitor: strobe model and run-length scoreboard
    int  m_len = 0;
    bit  m_prev = 0;
    bit  m_started = 0;
    always @(negedge clk) begin
        bit er, ef;
        er = rst_n && en && scl_in_s && !prev_m;
        ef = rst_n && en && !scl_in_s && prev_m;
        if (er || scl_rise) chk(scl_rise == er, "R7", "rise strobe", int'(scl_rise), int'(er));
        if (ef || scl_fall) chk(scl_fall == ef, "R7", "fall strobe", int'(scl_fall), int'(ef));
        if (!rst_n || !en) begin
            m_prev = 0; m_started = 0; m_len = 0;
        end else if (scl_drive_low != m_prev) begin
            if (m_started && q_len.size() > 0) begin
                int k, l;
                string r;
                k = q_kind.pop_front();
                l = q_len.pop_front();
                r = q_req.pop_front();
                chk(k == (m_prev ? 0 : 1), r, "run kind", m_prev ? 0 : 1, k);
                chk(l == m_len, r, "run length", m_len, l);
            end
            m_started = 1; m_len = 1; m_prev = scl_drive_low;
        end else begin
            m_len++;
        end
    end

    initial begin
        en = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset holds everything released even with en high
        chk(scl_drive_low == 0, "R1", "drive in reset", int'(scl_drive_low), 0);
        chk(!scl_rise && !scl_fall, "R1", "strobes in reset", int'(scl_rise | scl_fall), 0);
        #1; en = 1'b0; rst_n = 1'b1;
        step(); step();

        // R2 R3 R4: free-running clock
        start(5, 3);
        push(0, 5, "R2"); push(1, 5, "R3"); push(0, 5, "R4"); push(1, 5, "R4"); push(0, 5, "R2");
        finish_case("R2");

        // R8: zero counts act as one
        start(0, 0);
        push(0, 1, "R8"); push(1, 3, "R8"); push(0, 1, "R8"); push(1, 3, "R8");
        finish_case("R8");
        start(1, 1);
        push(0, 1, "R8"); push(1, 3, "R8"); push(0, 1, "R8");
        finish_case("R8");

        // R3: another device holds the line for 10 cycles
        start(4, 3);
        push(0, 4, "R3"); push(1, 11, "R3"); push(0, 4, "R3"); push(1, 5, "R3");
        wait_drive();
        other_pull = 1'b1;
        repeat (10) @(negedge clk);
        #1; other_pull = 1'b0;
        finish_case("R3");

        // R5: another device ends the high phase early (k=2)
        start(4, 8);
        push(0, 4, "R5"); push(1, 5, "R5"); push(0, 4, "R5"); push(1, 10, "R4");
        wait_drive();
        do @(negedge clk); while (!scl_rise);
        #1;
        repeat (2) @(negedge clk);
        #1; other_pull = 1'b1;
        repeat (2) @(negedge clk);
        #1; other_pull = 1'b0;
        finish_case("R5");

        // R6: long hold stretches the low pulse
        start(3, 2);
        push(0, 8, "R6"); push(1, 4, "R6"); push(0, 3, "R6");
        wait_drive();
        hold_low = 1'b1;
        repeat (7) @(negedge clk);
        #1; hold_low = 1'b0;
        finish_case("R6");

        // R6: short hold leaves the low count in charge
        start(6, 2);
        push(0, 6, "R6"); push(1, 4, "R6"); push(0, 6, "R6");
        wait_drive();
        hold_low = 1'b1;
        repeat (2) @(negedge clk);
        #1; hold_low = 1'b0;
        finish_case("R6");

        // R1: disable mid-phase, then line activity must give no strobes
        start(4, 3);
        wait_drive();
        step();
        en = 1'b0;
        @(negedge clk);
        chk(scl_drive_low == 0, "R1", "drive after disable", int'(scl_drive_low), 0);
        for (int i = 0; i < 6; i++) begin
            #1; other_pull = (i < 3);
            @(negedge clk);
            chk(!scl_drive_low && !scl_rise && !scl_fall, "R1", "outputs while disabled",
                int'({scl_drive_low, scl_rise, scl_fall}), 0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog act=1 exp=0");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule